// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized number of external lines plus one non-maskable input, and hands the core a single vectored request at a time. Each external line has a software enable, a sticky pending flag and an 8-bit priority. Every cycle the controller finds the most urgent pending, enabled source, and raises a registered request with that source's exception number if the source is more urgent than whatever handler is running.

The core answers with an acknowledge pulse when it takes the request. The taken exception becomes active and its pending flag clears. The core later signals end-of-service, and the controller retires the innermost active exception. Handlers can therefore nest to any depth, and the running priority falls back to that of the handler underneath. Software reaches the enables, the pending flags and the priorities through a small word-addressed register port with a combinational read.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset, `core_req` is low and the enable word (address 0), the pending word (address 2) and every priority word (address 8 and up) read zero.
- R2: Writing to address 0 sets the enable of every line whose bit is 1. Writing to address 1 clears the enable of every line whose bit is 1. A read of either address returns the enable vector, with bit n for line n.
- R3: A request on `irq_i[n]` latches pending bit n, which is visible at address 2 or 3, even while line n is disabled. A disabled line is never presented to the core, and it is presented once it is enabled.
- R4: Writing to address 2 sets pending bits with the same effect as a hardware request. Writing to address 3 clears the pending bits whose write bit is 1.
- R5: Among pending, enabled lines, the one with the smallest priority value is presented. External line n is reported as exception number 16+n.
- R6: When candidates share a priority value, the one with the lower exception number is presented.
- R7: A pulse on `nmi_i` is presented as exception number 2 ahead of every external line, priority 0 included. It needs no enable, and it also preempts an active external handler.
- R8: A pending source is presented only if it is strictly more urgent than the most urgent active exception. A source of equal or lower urgency waits.
- R9: `core_eos` retires the most urgent active exception. The running level then returns to the next active one, and a source that was waiting on the retired one is presented.
- R10: `core_req` comes from a register. `core_exc` holds steady while `core_req` is high and `core_ack` is low. An acknowledge drops `core_req` on the next cycle and clears the taken pending bit.
- R11: The priority of line n sits in word 8 + n/4, bits [8*(n%4)+7 : 8*(n%4)], and reads back from the same place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_IRQ | External request lines, active high |
| nmi_i | input | 1 | Non-maskable request, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| core_req | output | 1 | Vectored request to the core |
| core_exc | output | EXC_W | Exception number of the request |
| core_ack | input | 1 | Core takes the presented request |
| core_eos | input | 1 | Core finished the innermost handler |

## Verification
Arbitration is exercised with a mixed set of pending lines that holds one clear winner, a tied pair and a less urgent straggler. This separates selection by value from selection by index. Nesting is driven by pending a source equal in priority to the running handler, which must wait, and then a more urgent one, which must preempt. Two end-of-service pulses then show the level unwinding one step at a time. The non-maskable input is pulsed against a priority-0 line, both idle and in the middle of that line's handler. A hardware pulse on a disabled line shows that the pending state is latched but nothing is presented until the line is enabled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LVL_W        = 9;
    localparam int EXC_NMI      = 2;
    localparam int EXC_EXT_BASE = 16;
    localparam int ADDR_W       = 6;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_NMI  = '0;
    localparam lvl_t LVL_IDLE = '1;

    localparam logic [ADDR_W-1:0] A_EN_SET    = 6'd0;
    localparam logic [ADDR_W-1:0] A_EN_CLR    = 6'd1;
    localparam logic [ADDR_W-1:0] A_PD_SET    = 6'd2;
    localparam logic [ADDR_W-1:0] A_PD_CLR    = 6'd3;
    localparam logic [ADDR_W-1:0] A_PRIO_BASE = 6'd8;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pd_set;
        logic pd_clr;
    } wr_dec_t;

    // Programmable value p maps to level p+2, leaving 0 free for the NMI.
    function automatic lvl_t ext_lvl(input logic [7:0] p);
        return lvl_t'(p) + lvl_t'(2);
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    input  logic [NUM_IRQ-1:0]      line_set,
    input  logic [NUM_IRQ-1:0]      ack_clr,
    output logic [NUM_IRQ-1:0]      en_o,
    output logic [NUM_IRQ-1:0]      pend_o,
    output logic [NUM_IRQ-1:0][7:0] prio_o
);
    localparam int PW = (NUM_IRQ + 3) / 4;

    wr_dec_t dec;
    logic [NUM_IRQ-1:0] wmask;
    logic [NUM_IRQ-1:0] en_q, pend_q;
    logic [NUM_IRQ-1:0][7:0] prio_q;
    logic [PW*4-1:0][7:0] prio_pad;

    assign wmask = wdata[NUM_IRQ-1:0];

    always_comb begin
        dec.en_set = we && (addr == A_EN_SET);
        dec.en_clr = we && (addr == A_EN_CLR);
        dec.pd_set = we && (addr == A_PD_SET);
        dec.pd_clr = we && (addr == A_PD_CLR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            if (dec.en_set)      en_q <= en_q | wmask;
            else if (dec.en_clr) en_q <= en_q & ~wmask;
            pend_q <= (pend_q & ~(dec.pd_clr ? wmask : '0) & ~ack_clr)
                      | line_set | (dec.pd_set ? wmask : '0);
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[i] <= '0;
            else if (we && addr == A_PRIO_BASE + ADDR_W'(i / 4))
                prio_q[i] <= wdata[8*(i%4) +: 8];
        end
    end

    always_comb begin
        prio_pad = '0;
        for (int i = 0; i < NUM_IRQ; i++) prio_pad[i] = prio_q[i];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_EN_SET || addr == A_EN_CLR)
            rdata = 32'(en_q);
        else if (addr == A_PD_SET || addr == A_PD_CLR)
            rdata = 32'(pend_q);
        else
            for (int k = 0; k < PW; k++)
                if (addr == A_PRIO_BASE + ADDR_W'(k))
                    rdata = {prio_pad[4*k+3], prio_pad[4*k+2], prio_pad[4*k+1], prio_pad[4*k]};
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign prio_o = prio_q;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int M = 17,
    localparam int IW = (M > 1) ? $clog2(M) : 1
) (
    input  logic [M-1:0]       valid,
    input  lvl_t [M-1:0]       lvl,
    output logic               found,
    output logic [IW-1:0]      idx,
    output lvl_t               lvl_min
);
    lvl_t best;

    // Ascending scan with a strict compare: the lower index keeps a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = LVL_IDLE;
        for (int i = 0; i < M; i++) begin
            if (valid[i] && (!found || lvl[i] < best)) begin
                found = 1'b1;
                best  = lvl[i];
                idx   = IW'(i);
            end
        end
        lvl_min = found ? best : LVL_IDLE;
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    localparam int M     = NUM_IRQ + 1,
    localparam int IW    = $clog2(M),
    localparam int EXC_W = $clog2(NUM_IRQ + EXC_EXT_BASE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               nmi_i,
    input  logic               reg_we,
    input  logic [5:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               core_req,
    output logic [EXC_W-1:0]   core_exc,
    input  logic               core_ack,
    input  logic               core_eos
);
    logic [NUM_IRQ-1:0]      en, pend;
    logic [NUM_IRQ-1:0][7:0] prio;
    logic                    nmi_pend_q;
    logic [M-1:0]            act_q, acc_mask, pop_mask;
    lvl_t [M-1:0]            lvl_all;
    logic                    c_found, a_found;
    logic [IW-1:0]           c_idx, a_idx, req_idx_q;
    lvl_t                    c_lvl, cur_lvl;
    logic                    req_q, take;
    logic [EXC_W-1:0]        exc_q, c_exc;

    irqc_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .line_set(irq_i),
        .ack_clr(acc_mask[M-1:1]), .en_o(en), .pend_o(pend), .prio_o(prio)
    );

    assign lvl_all[0] = LVL_NMI;
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lvl
        assign lvl_all[i+1] = ext_lvl(prio[i]);
    end

    irqc_pick #(.M(M)) u_pend_pick (
        .valid({pend & en, nmi_pend_q}), .lvl(lvl_all),
        .found(c_found), .idx(c_idx), .lvl_min(c_lvl)
    );

    irqc_pick #(.M(M)) u_act_pick (
        .valid(act_q), .lvl(lvl_all),
        .found(a_found), .idx(a_idx), .lvl_min(cur_lvl)
    );

    assign take = req_q && core_ack;
    assign c_exc = (c_idx == '0) ? EXC_W'(EXC_NMI)
                                 : EXC_W'(EXC_EXT_BASE - 1) + EXC_W'(c_idx);

    always_comb begin
        acc_mask = '0;
        pop_mask = '0;
        if (take)               acc_mask[req_idx_q] = 1'b1;
        if (core_eos && a_found) pop_mask[a_idx]    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= '0;
            nmi_pend_q <= 1'b0;
            req_q      <= 1'b0;
            req_idx_q  <= '0;
            exc_q      <= '0;
        end else begin
            act_q <= (act_q & ~pop_mask) | acc_mask;
            if (nmi_i)            nmi_pend_q <= 1'b1;
            else if (acc_mask[0]) nmi_pend_q <= 1'b0;
            if (take) begin
                req_q <= 1'b0;
            end else if (!req_q && c_found && c_lvl < cur_lvl) begin
                req_q     <= 1'b1;
                req_idx_q <= c_idx;
                exc_q     <= c_exc;
            end
        end
    end

    assign core_req = req_q;
    assign core_exc = exc_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int M     = 17,
    parameter int EXC_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             core_req,
    input logic [EXC_W-1:0] core_exc,
    input logic             core_ack,
    input logic             core_eos,
    input logic             nmi_pend,
    input logic [M-1:0]     act
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        core_req && !core_ack |=> core_req && $stable(core_exc));

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        core_req && core_ack |=> !core_req);

    // R7
    nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_pend && !act[0] && !core_req |=> core_req && core_exc == EXC_W'(2));

    // R9
    eos_pop_chk: assert property (@(posedge clk) disable iff (rst)
        core_eos && !(core_req && core_ack) && (|act)
        |=> $countones(act) == $past($countones(act)) - 1);

    // R8
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        core_req && core_ack && !core_eos
        |=> $countones(act) == $past($countones(act)) + 1);
endmodule

bind irq_ctrl irqc_chk #(.M(NUM_IRQ + 1), .EXC_W(EXC_W)) u_chk (
    .clk(clk), .rst(rst), .core_req(core_req), .core_exc(core_exc),
    .core_ack(core_ack), .core_eos(core_eos), .nmi_pend(nmi_pend_q), .act(act_q)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    localparam int N     = 16;
    localparam int EXC_W = $clog2(N + 16);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N-1:0]     irq_i = '0;
    logic             nmi_i = 1'b0;
    logic             reg_we = 1'b0;
    logic [5:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             core_req;
    logic [EXC_W-1:0] core_exc;
    logic             core_ack = 1'b0;
    logic             core_eos = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_ctrl #(.NUM_IRQ(N)) i_irq_ctrl (
        .clk(clk), .rst(rst), .irq_i(irq_i), .nmi_i(nmi_i),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_req(core_req), .core_exc(core_exc),
        .core_ack(core_ack), .core_eos(core_eos)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack();
        @(negedge clk); core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
    endtask

    task automatic eos();
        @(negedge clk); core_eos = 1'b1;
        @(negedge clk); core_eos = 1'b0;
    endtask

    task automatic expect_req(input int exc, input string req);
        idle(2);
        check(core_req === 1'b1 && int'(core_exc) == exc, req, core_req ? int'(core_exc) : -1, exc);
    endtask

    task automatic expect_none(input string req);
        idle(3);
        check(core_req === 1'b0, req, int'(core_req), 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(core_req === 1'b0, "R1 req", int'(core_req), 0);
        rd(6'd0, d); check(d == 0, "R1 enable", int'(d), 0);
        rd(6'd2, d); check(d == 0, "R1 pending", int'(d), 0);
        rd(6'd9, d); check(d == 0, "R1 prio", int'(d), 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(6'd0, 32'h5);
        rd(6'd0, d); check(d == 32'h5, "R2 set", int'(d), 5);
        wr(6'd1, 32'h1);
        rd(6'd1, d); check(d == 32'h4, "R2 clear", int'(d), 4);
        wr(6'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_prio_map();
        logic [31:0] d;
        wr(6'd9, 32'h4433_2211);
        rd(6'd9, d); check(d == 32'h4433_2211, "R11 word9", int'(d), 32'h44332211);
        rd(6'd8, d); check(d == 0, "R11 word8 untouched", int'(d), 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        @(negedge clk); irq_i[3] = 1'b1;
        @(negedge clk); irq_i[3] = 1'b0;
        rd(6'd2, d); check(d == 32'h8, "R3 pend latched", int'(d), 8);
        expect_none("R3 disabled not presented");
        wr(6'd3, 32'h8);
        rd(6'd3, d); check(d == 0, "R4 clear pend", int'(d), 0);
        @(negedge clk); irq_i[3] = 1'b1;
        @(negedge clk); irq_i[3] = 1'b0;
        wr(6'd0, 32'h8);
        expect_req(19, "R3 presented once enabled");
        ack(); eos();
        wr(6'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(6'd8, 32'h0080_4000);
        wr(6'd9, 32'h2000_2000);
        wr(6'd0, 32'hA6);
        wr(6'd2, 32'hA6);
        expect_req(21, "R5 R6 lowest value, tie to lower number");
        idle(3);
        check(core_req && int'(core_exc) == 21, "R10 stable", int'(core_exc), 21);
        ack();
        rd(6'd2, d); check(d == 32'h86, "R10 ack clears pend", int'(d), 32'h86);
        expect_none("R8 equal priority waits");
        wr(6'd10, 32'h0000_1000);
        wr(6'd0, 32'h200);
        wr(6'd2, 32'h200);
        expect_req(25, "R8 more urgent preempts");
        ack();
        eos();
        expect_none("R9 back at level of irq5");
        eos();
        expect_req(23, "R9 waiting tie released");
        ack(); eos();
        expect_req(17, "R5 next by value");
        ack(); eos();
        expect_req(18, "R5 last");
        ack(); eos();
        expect_none("R9 all retired");
        wr(6'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_nmi();
        wr(6'd8, 32'h0);
        wr(6'd0, 32'h1);
        wr(6'd2, 32'h1);
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk); nmi_i = 1'b0;
        expect_req(16, "R10 request held until ack");
        ack();
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk); nmi_i = 1'b0;
        expect_req(2, "R7 nmi preempts active line");
        ack();
        wr(6'd2, 32'h1);
        expect_none("R8 line waits under nmi");
        eos();
        eos();
        expect_req(16, "R9 line after nmi retired");
        ack(); eos();
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk); nmi_i = 1'b0;
        expect_req(2, "R7 nmi from idle");
        ack(); eos();
        expect_none("R7 done");
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_prio_map();
        t_disabled();
        t_select();
        t_nmi();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule